// File: doc/BRIEF.md
# Early Branch Resolution and Wrong-Path Squash Control

This block steers instruction fetch around conditional branches in a five-stage in-order pipeline. It owns the program counter and the fetch/decode pipeline register. When the decode stage holds a branch, the block compares the two source operands for equality. It also computes the branch destination as the address of the following instruction plus a sign-extended byte displacement. Because the branch is resolved in decode, a redirect or a stall costs one cycle.

A static parameter selects how the fetch stage behaves while a branch sits in decode. Under the stall policy, every branch inserts one bubble, whatever its outcome. Under the predict-not-taken policy, fetch runs on sequentially. If the branch turns out taken, the one wrong-path instruction is cleared to a bubble before it can write any state. Under the delay-slot policy, the instruction after the branch always proceeds and the redirect takes effect behind it. A branch found in a delay slot raises an error flag and does not redirect.

The pipeline register carries a valid bit. A squashed or stalled slot arrives in decode with that bit low, so stages further down force its write enables off. Operand forwarding, the instruction memory and the register file sit outside this block.

Top module: `branchFlushCtl`

## Requirements
- R1: While reset is held and just after it is released, fetchPc is 0, idValid is 0, and stall, flush, redirect and slotError are all 0.
- R2: With no branch in decode, fetchPc advances by 4 on every clock. The decode register then holds valid=1, the previous fetchPc and the instruction word fetched at that address.
- R3: A valid branch in decode is taken exactly when idOpA equals idOpB. If idIsBranch is 0, or idValid is 0, then redirect, stall and flush all stay low whatever the operands are.
- R4: branchTarget equals idPc + 4 + the sign-extended DISP_W-bit byte displacement idDisp, computed modulo 2^ADDR_W. A negative displacement gives a target below the branch.
- R5: Under the predict-not-taken policy (POLICY = POL_PNT), a not-taken branch asserts neither stall nor flush. Fetch continues at fetchPc + 4 and the next decode slot is valid.
- R6: Under POL_PNT, a taken branch asserts flush and redirect in its decode cycle. In the next cycle idValid is 0 and fetchPc equals the target, and one cycle after that decode holds the target instruction. A redirect takes precedence over the sequential increment.
- R7: Under the stall policy (POLICY = POL_STALL), every valid branch asserts stall and the next decode slot is a bubble. If the branch is not taken, fetchPc holds at branch + 4. If it is taken, fetchPc becomes the target. flush stays 0 in both cases.
- R8: Under the delay-slot policy (POLICY = POL_SLOT), the instruction at branch + 4 enters decode valid in the next cycle. fetchPc becomes the target when the branch is taken and branch + 4 + 4 otherwise. Neither flush nor stall ever asserts.
- R9: Under POL_SLOT, a branch sitting in a delay slot asserts slotError and is treated as not taken: there is no redirect and fetch stays sequential. Under the other policies slotError stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchInstr | input | INSTR_W | Instruction word read at fetchPc |
| idIsBranch | input | 1 | Decoder flag: decode-stage instruction is a conditional branch |
| idDisp | input | DISP_W | Signed byte displacement of the decode-stage branch |
| idOpA | input | DATA_W | First compared operand |
| idOpB | input | DATA_W | Second compared operand |
| fetchPc | output | ADDR_W | Current fetch address |
| idValid | output | 1 | Decode slot holds a live instruction |
| idPc | output | ADDR_W | Address of the decode-stage instruction |
| idInstr | output | INSTR_W | Decode-stage instruction word |
| branchTarget | output | ADDR_W | Computed destination of the decode-stage branch |
| redirect | output | 1 | Next PC is branchTarget |
| stall | output | 1 | Stall-policy bubble inserted for a branch |
| flush | output | 1 | Wrong-path fetch squashed |
| slotError | output | 1 | Branch found in a delay slot |

## Verification
Three instances run in lockstep, one per policy. Each is driven with a taken branch, a not-taken branch and a backward branch, so a design that held the PC on a predicted not-taken path, or skipped the stall bubble when the branch falls through, shows up as a wrong fetchPc or idValid one cycle later. A target computed from the branch's own address instead of the following one, or with zero extension instead of sign extension, puts the backward-branch redirect at the wrong address. Two further cases are checked. A branch placed in a delay slot must not redirect. A non-branch with equal operands, and a branch on an invalid slot, must not trigger any control action.

// File: rtl/branchPkg.sv
package branchPkg;

  typedef enum logic [1:0] {
    POL_STALL = 2'd0,
    POL_PNT   = 2'd1,
    POL_SLOT  = 2'd2
  } branchPolicyE;

  typedef struct packed {
    logic redirect;  // next PC comes from the target adder
    logic squash;    // clear the wrong-path fetch
    logic stallBr;   // stall-policy bubble for this branch
    logic markSlot;  // next decode entry is a delay slot
    logic slotErr;   // branch found inside a delay slot
  } brStrobeT;

endpackage

// File: rtl/branchCtl.sv
module branchCtl
  import branchPkg::*;
#(
  parameter branchPolicyE POLICY = POL_PNT
) (
  input  logic     idValid,
  input  logic     idIsBranch,
  input  logic     idInSlot,
  input  logic     opsEqual,
  output brStrobeT strb
);

  logic brLive;
  logic brLegal;
  logic brTaken;

  assign brLive  = idValid & idIsBranch;
  assign brLegal = brLive & ~idInSlot;
  assign brTaken = brLegal & opsEqual;

  generate
    if (POLICY == POL_STALL) begin : g_stall
      always_comb begin
        strb          = '0;
        strb.redirect = brTaken;
        strb.stallBr  = brLegal;
      end
    end else if (POLICY == POL_PNT) begin : g_pnt
      always_comb begin
        strb          = '0;
        strb.redirect = brTaken;
        strb.squash   = brTaken;
      end
    end else begin : g_slot
      always_comb begin
        strb          = '0;
        strb.redirect = brTaken;
        strb.markSlot = brLegal;
        strb.slotErr  = brLive & idInSlot;
      end
    end
  endgenerate

endmodule

// File: rtl/branchDatapath.sv
module branchDatapath
  import branchPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int DATA_W  = 32,
  parameter int DISP_W  = 16,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  brStrobeT           strb,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic [DISP_W-1:0]  idDisp,
  input  logic [DATA_W-1:0]  idOpA,
  input  logic [DATA_W-1:0]  idOpB,
  output logic [ADDR_W-1:0]  fetchPc,
  output logic               idValid,
  output logic [ADDR_W-1:0]  idPc,
  output logic [INSTR_W-1:0] idInstr,
  output logic               idInSlot,
  output logic               opsEqual,
  output logic [ADDR_W-1:0]  branchTarget
);

  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(PC_STEP);
  localparam int                EXT_W  = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] pcNext;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] idPcReg;
  logic [INSTR_W-1:0] idInstrReg;
  logic              idValidReg;
  logic              idSlotReg;
  logic              bubble;
  logic              holdPc;

  // comparator and target adder, both in decode
  assign opsEqual     = (idOpA == idOpB);
  assign dispExt      = {{EXT_W{idDisp[DISP_W-1]}}, idDisp};
  assign branchTarget = idPcReg + STEP + dispExt;

  assign bubble = strb.squash | strb.stallBr;
  assign holdPc = strb.stallBr & ~strb.redirect;

  always_comb begin
    if (strb.redirect)  pcNext = branchTarget;
    else if (holdPc)    pcNext = pcReg;
    else                pcNext = pcReg + STEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg      <= '0;
      idValidReg <= 1'b0;
      idPcReg    <= '0;
      idInstrReg <= '0;
      idSlotReg  <= 1'b0;
    end else begin
      pcReg      <= pcNext;
      idValidReg <= ~bubble;
      idPcReg    <= pcReg;
      idInstrReg <= bubble ? '0 : fetchInstr;
      idSlotReg  <= strb.markSlot;
    end
  end

  assign fetchPc  = pcReg;
  assign idValid  = idValidReg;
  assign idPc     = idPcReg;
  assign idInstr  = idInstrReg;
  assign idInSlot = idSlotReg;

endmodule

// File: rtl/branchFlushCtl.sv
module branchFlushCtl
  import branchPkg::*;
#(
  parameter int           ADDR_W  = 32,
  parameter int           INSTR_W = 32,
  parameter int           DATA_W  = 32,
  parameter int           DISP_W  = 16,
  parameter int           PC_STEP = 4,
  parameter branchPolicyE POLICY  = POL_PNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic               idIsBranch,
  input  logic [DISP_W-1:0]  idDisp,
  input  logic [DATA_W-1:0]  idOpA,
  input  logic [DATA_W-1:0]  idOpB,
  output logic [ADDR_W-1:0]  fetchPc,
  output logic               idValid,
  output logic [ADDR_W-1:0]  idPc,
  output logic [INSTR_W-1:0] idInstr,
  output logic [ADDR_W-1:0]  branchTarget,
  output logic               redirect,
  output logic               stall,
  output logic               flush,
  output logic               slotError
);

  brStrobeT strb;
  logic     idInSlot;
  logic     opsEqual;

  branchCtl #(.POLICY(POLICY)) uCtl (
    .idValid    (idValid),
    .idIsBranch (idIsBranch),
    .idInSlot   (idInSlot),
    .opsEqual   (opsEqual),
    .strb       (strb)
  );

  branchDatapath #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W),
    .DATA_W  (DATA_W),
    .DISP_W  (DISP_W),
    .PC_STEP (PC_STEP)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .fetchInstr   (fetchInstr),
    .idDisp       (idDisp),
    .idOpA        (idOpA),
    .idOpB        (idOpB),
    .fetchPc      (fetchPc),
    .idValid      (idValid),
    .idPc         (idPc),
    .idInstr      (idInstr),
    .idInSlot     (idInSlot),
    .opsEqual     (opsEqual),
    .branchTarget (branchTarget)
  );

  assign redirect  = strb.redirect;
  assign stall     = strb.stallBr;
  assign flush     = strb.squash;
  assign slotError = strb.slotErr;

endmodule

// File: rtl/branchFlushCtlChk.sv
module branchFlushCtlChk
  import branchPkg::*;
#(
  parameter int           ADDR_W  = 32,
  parameter int           PC_STEP = 4,
  parameter branchPolicyE POLICY  = POL_PNT
) (
  input logic              clk,
  input logic              rstN,
  input logic              idIsBranch,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              idValid,
  input logic [ADDR_W-1:0] branchTarget,
  input logic              redirect,
  input logic              stall,
  input logic              flush,
  input logic              slotError
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  // R1: a cycle under reset is followed by a zero fetch address and an empty decode slot
  a_r1_reset_empty: assert property (@(posedge clk)
    !rstN |=> (fetchPc == '0) && !idValid);

  // R2: no redirect and no stall means a sequential step
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (!redirect && !stall) |=> fetchPc == $past(fetchPc) + STEP);

  // R3: control actions need a live branch in decode
  a_r3_needs_branch: assert property (@(posedge clk) disable iff (!rstN)
    (redirect || stall || flush) |-> (idValid && idIsBranch));

  // R6: redirect loads the computed target
  a_r6_redirect_pc: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> fetchPc == $past(branchTarget));

  // R6: a squash leaves a bubble in decode
  a_r6_flush_bubble: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !idValid);

  // R7: a stall that does not redirect holds the fetch address and leaves a bubble
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !redirect) |=> (fetchPc == $past(fetchPc)) && !idValid);

  // R8: delay-slot policy never squashes or stalls
  a_r8_slot_no_flush: assert property (@(posedge clk) disable iff (!rstN)
    (POLICY == POL_SLOT) |-> (!flush && !stall));

  // R9: an illegal slot branch never redirects, and only the slot policy flags it
  a_r9_slot_err: assert property (@(posedge clk) disable iff (!rstN)
    slotError |-> (!redirect && POLICY == POL_SLOT));

endmodule

bind branchFlushCtl branchFlushCtlChk #(
  .ADDR_W  (ADDR_W),
  .PC_STEP (PC_STEP),
  .POLICY  (POLICY)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .idIsBranch   (idIsBranch),
  .fetchPc      (fetchPc),
  .idValid      (idValid),
  .branchTarget (branchTarget),
  .redirect     (redirect),
  .stall        (stall),
  .flush        (flush),
  .slotError    (slotError)
);

// File: tb/tb_branchFlushCtl.sv
module tb_branchFlushCtl;
  import branchPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] imemWord(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  logic        isBr = 1'b0;
  logic [15:0] disp = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;

  // outputs: index 0 = predict-not-taken, 1 = stall, 2 = delay slot
  logic [31:0] fPc [3];
  logic        iVal [3];
  logic [31:0] iPc [3];
  logic [31:0] iIns [3];
  logic [31:0] tgt [3];
  logic        rdr [3];
  logic        stl [3];
  logic        fls [3];
  logic        sErr [3];
  logic [31:0] fIns [3];

  always_comb for (int k = 0; k < 3; k++) fIns[k] = imemWord(fPc[k]);

  branchFlushCtl #(.POLICY(POL_PNT)) dut (
    .clk(clk), .rstN(rstN), .fetchInstr(fIns[0]), .idIsBranch(isBr),
    .idDisp(disp), .idOpA(opA), .idOpB(opB), .fetchPc(fPc[0]),
    .idValid(iVal[0]), .idPc(iPc[0]), .idInstr(iIns[0]),
    .branchTarget(tgt[0]), .redirect(rdr[0]), .stall(stl[0]),
    .flush(fls[0]), .slotError(sErr[0]));

  branchFlushCtl #(.POLICY(POL_STALL)) dutStall (
    .clk(clk), .rstN(rstN), .fetchInstr(fIns[1]), .idIsBranch(isBr),
    .idDisp(disp), .idOpA(opA), .idOpB(opB), .fetchPc(fPc[1]),
    .idValid(iVal[1]), .idPc(iPc[1]), .idInstr(iIns[1]),
    .branchTarget(tgt[1]), .redirect(rdr[1]), .stall(stl[1]),
    .flush(fls[1]), .slotError(sErr[1]));

  branchFlushCtl #(.POLICY(POL_SLOT)) dutSlot (
    .clk(clk), .rstN(rstN), .fetchInstr(fIns[2]), .idIsBranch(isBr),
    .idDisp(disp), .idOpA(opA), .idOpB(opB), .fetchPc(fPc[2]),
    .idValid(iVal[2]), .idPc(iPc[2]), .idInstr(iIns[2]),
    .branchTarget(tgt[2]), .redirect(rdr[2]), .stall(stl[2]),
    .flush(fls[2]), .slotError(sErr[2]));

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setBr(input logic b, input logic [31:0] a, input logic [31:0] c,
                       input logic [15:0] d);
    isBr = b; opA = a; opB = c; disp = d;
    #1;
  endtask

  task automatic doReset(input int nRun);
    @(negedge clk);
    setBr(1'b0, 0, 0, 0);
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
    repeat (nRun) tick();
  endtask

  task automatic tReset();
    @(negedge clk);
    rstN = 1'b0;
    tick();
    #1;
    for (int k = 0; k < 3; k++) begin
      chk("R1 pc in reset", fPc[k], 0);
      chk("R1 idValid in reset", {31'b0, iVal[k]}, 0);
      chk("R1 controls idle", {28'b0, rdr[k], stl[k], fls[k], sErr[k]}, 0);
    end
  endtask

  task automatic tSequential();
    doReset(0);
    chk("R1 pc after release", fPc[0], 0);
    chk("R1 idValid after release", {31'b0, iVal[0]}, 0);
    tick();
    for (int n = 1; n <= 4; n++) begin
      for (int k = 0; k < 3; k++) begin
        chk("R2 fetchPc step", fPc[k], 32'(4 * n));
        chk("R2 decode valid", {31'b0, iVal[k]}, 1);
        chk("R2 decode pc", iPc[k], 32'(4 * (n - 1)));
        chk("R2 decode instr", iIns[k], imemWord(32'(4 * (n - 1))));
      end
      tick();
    end
  endtask

  task automatic tNonBranch();
    doReset(3);
    setBr(1'b0, 32'h55, 32'h55, 16'd32);
    for (int k = 0; k < 3; k++)
      chk("R3 non-branch idle", {29'b0, rdr[k], stl[k], fls[k]}, 0);
    tick();
    for (int k = 0; k < 3; k++) chk("R3 non-branch fetch", fPc[k], 16);
    // branch flag on an empty decode slot after reset
    doReset(0);
    setBr(1'b1, 32'h7, 32'h7, 16'd32);
    for (int k = 0; k < 3; k++)
      chk("R3 invalid slot idle", {29'b0, rdr[k], stl[k], fls[k]}, 0);
    tick();
    setBr(1'b0, 0, 0, 0);
    for (int k = 0; k < 3; k++) chk("R3 invalid slot fetch", fPc[k], 4);
  endtask

  task automatic tTaken();
    doReset(3);  // decode pc 8, fetch pc 12
    setBr(1'b1, 32'hABCD, 32'hABCD, 16'd32);
    for (int k = 0; k < 3; k++) begin
      chk("R4 forward target", tgt[k], 44);
      chk("R3 equal is taken", {31'b0, rdr[k]}, 1);
    end
    chk("R6 flush on taken", {31'b0, fls[0]}, 1);
    chk("R6 no stall", {31'b0, stl[0]}, 0);
    chk("R7 stall on taken", {31'b0, stl[1]}, 1);
    chk("R7 no flush", {31'b0, fls[1]}, 0);
    chk("R8 no flush/stall", {30'b0, fls[2], stl[2]}, 0);
    tick();
    setBr(1'b0, 0, 0, 0);
    chk("R6 fetch target", fPc[0], 44);
    chk("R6 bubble", {31'b0, iVal[0]}, 0);
    chk("R7 fetch target", fPc[1], 44);
    chk("R7 bubble", {31'b0, iVal[1]}, 0);
    chk("R8 fetch target", fPc[2], 44);
    chk("R8 slot valid", {31'b0, iVal[2]}, 1);
    chk("R8 slot pc", iPc[2], 12);
    chk("R8 slot instr", iIns[2], imemWord(12));
    tick();
    for (int k = 0; k < 3; k++) begin
      chk("R6 target in decode", iPc[k], 44);
      chk("R6 target valid", {31'b0, iVal[k]}, 1);
      chk("R6 fetch past target", fPc[k], 48);
    end
  endtask

  task automatic tNotTaken();
    doReset(3);
    setBr(1'b1, 32'h1, 32'h2, 16'd32);
    for (int k = 0; k < 3; k++) chk("R3 unequal not taken", {31'b0, rdr[k]}, 0);
    chk("R5 no flush/stall", {30'b0, fls[0], stl[0]}, 0);
    chk("R7 stall when not taken", {31'b0, stl[1]}, 1);
    chk("R8 no flush/stall", {30'b0, fls[2], stl[2]}, 0);
    tick();
    setBr(1'b0, 0, 0, 0);
    chk("R5 fetch continues", fPc[0], 16);
    chk("R5 next valid", {31'b0, iVal[0]}, 1);
    chk("R5 next pc", iPc[0], 12);
    chk("R7 fetch held", fPc[1], 12);
    chk("R7 bubble", {31'b0, iVal[1]}, 0);
    chk("R8 fetch continues", fPc[2], 16);
    chk("R8 slot pc", iPc[2], 12);
    tick();
    chk("R7 fall-through in decode", iPc[1], 12);
    chk("R7 fall-through valid", {31'b0, iVal[1]}, 1);
    chk("R7 fetch resumes", fPc[1], 16);
  endtask

  task automatic tBackward();
    doReset(6);  // decode pc 20
    setBr(1'b1, 32'h0, 32'h0, -16'sd16);
    for (int k = 0; k < 3; k++) chk("R4 backward target", tgt[k], 8);
    tick();
    setBr(1'b0, 0, 0, 0);
    for (int k = 0; k < 3; k++) chk("R4 backward fetch", fPc[k], 8);
  endtask

  task automatic tSlotError();
    doReset(3);
    setBr(1'b1, 32'h9, 32'h9, 16'd32);  // taken, target 44
    tick();
    setBr(1'b1, 32'h3, 32'h3, 16'd100); // branch inside delay slot (pc 12)
    chk("R9 slot error raised", {31'b0, sErr[2]}, 1);
    chk("R9 no redirect", {31'b0, rdr[2]}, 0);
    chk("R9 other policies quiet", {30'b0, sErr[0], sErr[1]}, 0);
    tick();
    setBr(1'b0, 0, 0, 0);
    chk("R9 fetch sequential", fPc[2], 48);
    chk("R9 decode target", iPc[2], 44);
    chk("R9 error cleared", {31'b0, sErr[2]}, 0);
  endtask

  initial begin
    tReset();
    tSequential();
    tNonBranch();
    tTaken();
    tNotTaken();
    tBackward();
    tSlotError();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule